// File: doc/BRIEF.md
# Signaling NaN Quieting Unit

This unit examines one single-precision floating-point operand and reports whether it is a NaN and, if so, whether that NaN is signaling or quiet. A mode input picks which polarity of the quiet-indicator bit (the top bit of the fraction field) is in force. With the newer convention a clear indicator marks a signaling NaN. With the legacy convention a set indicator marks it.

When the operand is a signaling NaN, the unit returns the quieted form of that NaN and raises an invalid-operation flag. Under the newer convention, quieting sets the indicator bit. Under the legacy convention, quieting clears the indicator bit. If that clearing would leave a zero fraction, which would turn the value into an infinity, the unit also sets the next fraction bit down so that the result is still a NaN.

Any other operand is returned unchanged with the flag low. The decision logic is combinational. All outputs are captured in registers on the rising clock edge, so they appear one cycle after the inputs are sampled.

Top module: `snan_quiet_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero at that edge.
- R2: Outputs update only at a rising clock edge and reflect the inputs sampled at that edge. An input change between edges leaves the outputs as they were.
- R3: `nan_o` is 1 exactly when exponent bits [30:23] are all ones and fraction bits [22:0] are nonzero. An all-ones exponent with a zero fraction (infinity) gives `nan_o` = 0.
- R4: `snan_o` is 1 exactly when the operand is a NaN and `mode_new_i` XOR bit 22 equals 1. With `mode_new_i`=1, a clear bit 22 means signaling. With `mode_new_i`=0, a set bit 22 means signaling.
- R5: For a signaling NaN with `mode_new_i`=1, `quiet_o` equals the operand with bit 22 set, and all other bits are unchanged.
- R6: For a signaling NaN with `mode_new_i`=0, `quiet_o` equals the operand with bit 22 cleared. If bits [22:0] are then all zero, bit 21 is also set. Sign and exponent bits are unchanged.
- R7: For any operand that is not a signaling NaN (numbers, infinities, quiet NaNs), `quiet_o` equals the operand and `invalid_o` is 0.
- R8: `invalid_o` equals `snan_o`. Whenever `invalid_o` is 1, `quiet_o` is a quiet NaN under the selected convention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 32 | Single-precision operand |
| mode_new_i | input | 1 | 1 = newer quiet-bit convention, 0 = legacy convention |
| nan_o | output | 1 | Registered: operand is a NaN |
| snan_o | output | 1 | Registered: operand is a signaling NaN |
| quiet_o | output | 32 | Registered: quieted NaN, or the operand passed through |
| invalid_o | output | 1 | Registered: invalid-operation flag |

## Verification
The case that is hardest to reach is the legacy repair. It needs a legacy-mode signaling NaN whose only set fraction bit is the indicator, so that clearing the indicator leaves a zero fraction. Uniform random 32-bit words almost never produce that operand, and they produce NaNs of any kind only rarely. The stimulus therefore forces the exponent to all ones in most draws and often masks the fraction down to a few bits. It also applies the lone-indicator operands directly under both signs and both modes.

// File: rtl/snan_quiet_pkg.sv
package snan_quiet_pkg;
  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_SUB  = 3'd1,
    FC_NORM = 3'd2,
    FC_INF  = 3'd3,
    FC_NAN  = 3'd4
  } fclass_e;
endpackage

// File: rtl/snan_class_decode.sv
module snan_class_decode
  import snan_quiet_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_i,
  output fclass_e           cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_ones, exp_zero, frac_zero;

  assign exp_f     = word_i[FRAC_W +: EXP_W];
  assign frac_f    = word_i[FRAC_W-1:0];
  assign exp_ones  = &exp_f;
  assign exp_zero  = ~|exp_f;
  assign frac_zero = ~|frac_f;

  always_comb begin
    if (exp_ones)      cls_o = frac_zero ? FC_INF  : FC_NAN;
    else if (exp_zero) cls_o = frac_zero ? FC_ZERO : FC_SUB;
    else               cls_o = FC_NORM;
  end
endmodule

// File: rtl/snan_quieter.sv
module snan_quieter #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int QBIT   = FRAC_W - 1,
  localparam int RBIT   = FRAC_W - 2
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              is_nan_i,
  input  logic              mode_new_i,
  output logic              snan_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] q_mask;
  logic [WORD_W-1:0] r_mask;
  logic [WORD_W-1:0] set_form;
  logic [WORD_W-1:0] clr_form;
  logic [WORD_W-1:0] legacy_form;

  assign q_mask = WORD_W'(1) << QBIT;
  assign r_mask = WORD_W'(1) << RBIT;

  assign snan_o = is_nan_i & (mode_new_i ^ word_i[QBIT]);

  assign set_form = word_i | q_mask;
  assign clr_form = word_i & ~q_mask;

  // Clearing the indicator may empty the fraction; keep the value a NaN.
  always_comb begin
    if (clr_form[FRAC_W-1:0] == '0) legacy_form = clr_form | r_mask;
    else                            legacy_form = clr_form;
  end

  always_comb begin
    if (!snan_o)        word_o = word_i;
    else if (mode_new_i) word_o = set_form;
    else                 word_o = legacy_form;
  end
endmodule

// File: rtl/snan_quiet_unit.sv
module snan_quiet_unit
  import snan_quiet_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [EXP_W+FRAC_W:0]       op_i,
  input  logic                        mode_new_i,
  output logic                        nan_o,
  output logic                        snan_o,
  output logic [EXP_W+FRAC_W:0]       quiet_o,
  output logic                        invalid_o
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  fclass_e           cls;
  logic              is_nan_c;
  logic              snan_c;
  logic [WORD_W-1:0] word_c;

  snan_class_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_decode (
    .word_i (op_i),
    .cls_o  (cls)
  );

  assign is_nan_c = (cls == FC_NAN);

  snan_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .word_i     (op_i),
    .is_nan_i   (is_nan_c),
    .mode_new_i (mode_new_i),
    .snan_o     (snan_c),
    .word_o     (word_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nan_o     <= 1'b0;
      snan_o    <= 1'b0;
      quiet_o   <= '0;
      invalid_o <= 1'b0;
    end else begin
      nan_o     <= is_nan_c;
      snan_o    <= snan_c;
      quiet_o   <= word_c;
      invalid_o <= snan_c;
    end
  end
endmodule

// File: rtl/snan_quiet_checker.sv
module snan_quiet_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] op_i,
  input logic              mode_new_i,
  input logic              nan_o,
  input logic              snan_o,
  input logic [WORD_W-1:0] quiet_o,
  input logic              invalid_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!nan_o && !snan_o && !invalid_o && quiet_o == '0));

  p_snan_is_nan_r4: assert property (@(posedge clk) disable iff (rst)
    snan_o |-> nan_o);

  p_flag_matches_r8: assert property (@(posedge clk) disable iff (rst)
    invalid_o == snan_o);

  p_result_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (invalid_o && !$past(rst)) |->
      ((&quiet_o[FRAC_W +: EXP_W]) && (|quiet_o[FRAC_W-1:0]) &&
       (quiet_o[FRAC_W-1] == $past(mode_new_i))));

  p_keep_sign_exp_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> quiet_o[WORD_W-1:FRAC_W] == $past(op_i[WORD_W-1:FRAC_W]));

  p_pass_through_r7: assert property (@(posedge clk) disable iff (rst)
    (!invalid_o && !$past(rst)) |-> quiet_o == $past(op_i));
endmodule

bind snan_quiet_unit snan_quiet_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_i       (op_i),
  .mode_new_i (mode_new_i),
  .nan_o      (nan_o),
  .snan_o     (snan_o),
  .quiet_o    (quiet_o),
  .invalid_o  (invalid_o)
);

// File: tb/test_snan_quiet_unit.sv
module test_snan_quiet_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_i = '0;
  logic        mode_new_i = 1'b0;
  logic        nan_o, snan_o, invalid_o;
  logic [31:0] quiet_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  snan_quiet_unit i_snan_quiet_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .mode_new_i(mode_new_i),
    .nan_o(nan_o), .snan_o(snan_o), .quiet_o(quiet_o), .invalid_o(invalid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
  endfunction

  function automatic bit exp_snan(input logic [31:0] v, input logic m);
    return exp_nan(v) && (m ^ v[22]);
  endfunction

  function automatic logic [31:0] exp_quiet(input logic [31:0] v, input logic m);
    logic [31:0] r;
    r = v;
    if (exp_snan(v, m)) begin
      if (m) r[22] = 1'b1;
      else begin
        r[22] = 1'b0;
        if (r[22:0] == 23'd0) r[21] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic check1(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h (op %h mode %0b)", req, act, expv, op_i, mode_new_i);
    end
  endtask

  task automatic apply(input logic [31:0] v, input logic m);
    logic en, es;
    @(negedge clk);
    op_i = v;
    mode_new_i = m;
    @(posedge clk);
    #1;
    en = exp_nan(v);
    es = exp_snan(v, m);
    check1("R3", {31'd0, nan_o}, {31'd0, en});
    check1("R4", {31'd0, snan_o}, {31'd0, es});
    check1("R8", {31'd0, invalid_o}, {31'd0, es});
    if (!es)    check1("R7", quiet_o, v);
    else if (m) check1("R5", quiet_o, exp_quiet(v, m));
    else        check1("R6", quiet_o, exp_quiet(v, m));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    op_i = 32'h7F80_0001;
    mode_new_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs cleared under reset
    check1("R1", quiet_o, 32'd0);
    check1("R1", {29'd0, nan_o, snan_o, invalid_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R3 corner cases: infinities, zeros, numbers
    apply(32'h7F80_0000, 1'b1);
    apply(32'hFF80_0000, 1'b0);
    apply(32'h0000_0000, 1'b1);
    apply(32'h8000_0001, 1'b0);
    apply(32'h3F80_0000, 1'b1);
    // R5: newer-convention signaling NaNs
    apply(32'h7F80_0001, 1'b1);
    apply(32'hFFBF_FFFF, 1'b1);
    // R6: legacy, including the repair case with lone indicator bit
    apply(32'h7FC0_0000, 1'b0);
    apply(32'hFFC0_0000, 1'b0);
    apply(32'h7FC0_0001, 1'b0);
    // R7: quiet NaNs in each convention pass through
    apply(32'h7FC0_0000, 1'b1);
    apply(32'h7F80_0001, 1'b0);

    // R2: input change between edges does not move outputs
    apply(32'h7F80_0001, 1'b1);
    @(negedge clk);
    op_i = 32'h1234_5678;
    mode_new_i = 1'b0;
    #1;
    check1("R2", quiet_o, 32'h7FC0_0001);
    check1("R2", {31'd0, invalid_o}, 32'd1);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] v;
      int sel;
      v = $urandom;
      sel = $urandom_range(0, 9);
      if (sel < 7) v[30:23] = 8'hFF;
      if (sel < 3) v[21:0] = v[21:0] & {19'd0, 3'b111} & {22{v[0] | v[1]}};
      apply(v, 1'(($urandom >> 3) & 1));
    end

    // R1 again: reset mid-run clears outputs
    apply(32'h7F80_0001, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check1("R1", quiet_o, 32'd0);
    check1("R1", {31'd0, invalid_o}, 32'd0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule